// File: doc/BRIEF.md
# Interrupt Pending and Priority Controller

This block sits between a set of peripheral interrupt sources and an 8051-family processor core. It keeps one pending bit per interrupt vector. It gates those bits with a global enable and a per-vector enable, and it picks one vector to present to the core. The pick uses three priority levels and a fixed polling order. The core answers with a one-cycle entry acknowledge that carries the vector index, and later with a return pulse that leaves the current service routine. There are thirteen vectors. Vector 2e is external channel e and vector 2e+1 is timer e. The remaining vectors are index 4 UART, 5 Timer 2, 6 UART2, 7 temperature ADC, 8 SPI/I2C port, 9 RTC, 10 watchdog, 11 energy DSP and 12 power-supply monitor.

Each group of sources clears its pending bit in its own way. Edge-mode external requests and timer overflows are cleared when their vector is entered. Temperature and serial-port events are latched and leave only through vector entry. RTC, watchdog and the shared multi-source vectors mirror the level of their source flags, so only software clearing those flags removes them. While the core is powered down, the external pins leave the external flags alone. A separate wake input instead raises the matching external vector.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset every pending bit is 0, no request is presented, and nothing is in service.
- R2: A vector is presented only when `gl_en` and its `vec_en` bit are both 1. A pending bit stays set and visible on `pend_o` while it is masked.
- R3: The power-supply-monitor vector (index 12) is the only member of the top level. When it is pending and enabled, and no top-level routine is running, it is presented over every other vector whatever the `vec_hi` bits say.
- R4: Every other vector is high level when its `vec_hi` bit is 1 and low level otherwise. The highest level wins. Among equal levels the lowest vector index wins.
- R5: A vector is presented only if its level is strictly above the highest level in service. `ack` marks the acknowledged vector's level as in service, and `reti` removes the highest level in service.
- R6: In edge mode (`ext_edge[e]`=1) a high-to-low change on `ext_n[e]` sets the external flag of vector 2e one cycle later. Entry of vector 2e clears it.
- R7: In level mode (`ext_edge[e]`=0) vector 2e is pending exactly while `ext_n[e]` was low on the previous clock. Entry does not clear it, so it is presented again until the pin goes high.
- R8: A pulse on `tmr_ovf[e]` makes vector 2e+1 pending on the next cycle. Entry of that vector clears it.
- R9: A pulse on `temp_evt` or `serp_evt` latches vector 7 or 8. The latch holds while the vector is disabled and clears only on entry of that vector.
- R10: Vector 9 is pending one cycle after `rtc_alarm` or `rtc_tick` is 1. Entry leaves it pending, and it drops one cycle after both flags are 0.
- R11: Vectors 4, 5, 6, 10, 11 and 12 follow their request inputs with one cycle of delay, and entry does not clear them.
- R12: While `core_off` is 1, changes on `ext_n` do not set the external flags. A pulse on `wake_ext[e]` makes vector 2e pending, and it stays pending until that vector is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gl_en | input | 1 | Global interrupt enable |
| vec_en | input | 13 | Per-vector enable |
| vec_hi | input | 13 | Per-vector high-level select (bit 12 unused) |
| ext_n | input | 2 | External request pins, active low |
| ext_edge | input | 2 | 1 = falling-edge mode, 0 = low-level mode |
| core_off | input | 1 | Core is in deep sleep |
| wake_ext | input | 2 | Wake event pulse per external channel |
| tmr_ovf | input | 2 | Timer 0/1 overflow pulse |
| temp_evt | input | 1 | Temperature ADC done pulse |
| serp_evt | input | 1 | SPI/I2C event pulse |
| uart_req | input | 1 | UART flags (level) |
| tmr2_req | input | 1 | Timer 2 flags (level) |
| uart2_req | input | 1 | UART2 flags (level) |
| rtc_alarm | input | 1 | RTC alarm flag |
| rtc_tick | input | 1 | RTC interval flag |
| wdt_req | input | 1 | Watchdog timeout flag |
| dsp_req | input | 1 | Energy DSP flags (level) |
| psm_req | input | 1 | Power-supply monitor flags (level) |
| ack | input | 1 | Vector entry pulse |
| ack_vec | input | 4 | Index of the vector being entered |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | A vector is presented |
| irq_vec | output | 4 | Presented vector index |
| pend_o | output | 13 | Pending bit per vector |

## Verification
The assertions assume a well-behaved core. It pulses `ack` only for a vector that is being presented, it never raises `ack` and `reti` in the same cycle, and it sends `reti` only while some level is in service. Event inputs are taken to be one-cycle pulses. The stimulus follows these rules: every acknowledge names the vector currently on `irq_vec` and is followed by a single return. The behavioural model in the bench follows the same rules, so the per-cycle comparison never reaches an ordering the core could not produce.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam int NVEC = 13;
    localparam int NEXT = 2;
    localparam int VW   = $clog2(NVEC);
    localparam int NLVL = 3;

    typedef enum logic [VW-1:0] {
        V_EXT0 = 4'd0, V_TMR0 = 4'd1, V_EXT1 = 4'd2, V_TMR1 = 4'd3,
        V_UART = 4'd4, V_TMR2 = 4'd5, V_UART2 = 4'd6, V_TEMP = 4'd7,
        V_SERP = 4'd8, V_RTC = 4'd9, V_WDT = 4'd10, V_DSP = 4'd11,
        V_PSM  = 4'd12
    } vec_e;

    typedef logic [1:0] lvl_t;   // 0 none, 1 low, 2 high, 3 top

    typedef struct packed {
        logic          req;
        logic [VW-1:0] vec;
        lvl_t          lvl;
    } pick_t;

    function automatic lvl_t vec_level(input logic [VW-1:0] v,
                                       input logic [NVEC-1:0] hi);
        if (v == V_PSM)       return 2'd3;
        if (int'(v) >= NVEC)  return 2'd1;
        return hi[v] ? 2'd2 : 2'd1;
    endfunction
endpackage

// File: rtl/ipc_pulse_latch.sv
module ipc_pulse_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set | (q & ~clr);
    end
endmodule

// File: rtl/ipc_sources.sv
module ipc_sources
    import ipc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NEXT-1:0]     ext_n,
    input  logic [NEXT-1:0]     ext_edge,
    input  logic                core_off,
    input  logic [NEXT-1:0]     wake_ext,
    input  logic [NEXT-1:0]     tmr_ovf,
    input  logic                temp_evt,
    input  logic                serp_evt,
    input  logic                uart_req,
    input  logic                tmr2_req,
    input  logic                uart2_req,
    input  logic                rtc_req,
    input  logic                wdt_req,
    input  logic                dsp_req,
    input  logic                psm_req,
    input  logic [NVEC-1:0]     clr,
    output logic [NVEC-1:0]     pend
);
    // External channels and their paired timers: ext e -> 2e, timer e -> 2e+1
    for (genvar e = 0; e < NEXT; e++) begin : g_ext
        logic pin_q, flag, wake_q, tmr_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                pin_q <= 1'b1;
                flag  <= 1'b0;
            end else begin
                pin_q <= ext_n[e];
                if (!core_off) begin
                    if (ext_edge[e]) flag <= (pin_q & ~ext_n[e]) | (flag & ~clr[2*e]);
                    else             flag <= ~ext_n[e];
                end else if (ext_edge[e]) begin
                    flag <= flag & ~clr[2*e];
                end
            end
        end

        ipc_pulse_latch u_wake (.clk(clk), .rst(rst), .set(wake_ext[e]),
                                .clr(clr[2*e]), .q(wake_q));
        ipc_pulse_latch u_tmr  (.clk(clk), .rst(rst), .set(tmr_ovf[e]),
                                .clr(clr[2*e+1]), .q(tmr_q));

        assign pend[2*e]   = flag | wake_q;
        assign pend[2*e+1] = tmr_q;
    end

    // Latched single-event sources, cleared only on entry
    logic temp_q, serp_q;
    ipc_pulse_latch u_temp (.clk(clk), .rst(rst), .set(temp_evt),
                            .clr(clr[V_TEMP]), .q(temp_q));
    ipc_pulse_latch u_serp (.clk(clk), .rst(rst), .set(serp_evt),
                            .clr(clr[V_SERP]), .q(serp_q));

    // Flag-following sources, cleared by software at the peripheral
    logic [6:0] lvl_q;
    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= {psm_req, dsp_req, wdt_req, rtc_req, uart2_req, tmr2_req, uart_req};
    end

    assign pend[V_UART]  = lvl_q[0];
    assign pend[V_TMR2]  = lvl_q[1];
    assign pend[V_UART2] = lvl_q[2];
    assign pend[V_TEMP]  = temp_q;
    assign pend[V_SERP]  = serp_q;
    assign pend[V_RTC]   = lvl_q[3];
    assign pend[V_WDT]   = lvl_q[4];
    assign pend[V_DSP]   = lvl_q[5];
    assign pend[V_PSM]   = lvl_q[6];
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
    import ipc_pkg::*;
(
    input  logic            gl_en,
    input  logic [NVEC-1:0] vec_en,
    input  logic [NVEC-1:0] vec_hi,
    input  logic [NVEC-1:0] pend,
    input  lvl_t            cur_lvl,
    output pick_t           pick
);
    always_comb begin
        pick = '0;
        // scan downward with >= so the lowest index wins a tie
        for (int v = NVEC - 1; v >= 0; v--) begin
            lvl_t l;
            l = vec_level(VW'(v), vec_hi);
            if (gl_en && vec_en[v] && pend[v] && (l > cur_lvl) && (l >= pick.lvl)) begin
                pick.req = 1'b1;
                pick.vec = VW'(v);
                pick.lvl = l;
            end
        end
    end
endmodule

// File: rtl/ipc_service.sv
module ipc_service
    import ipc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ack,
    input  logic [VW-1:0]   ack_vec,
    input  logic [NVEC-1:0] vec_hi,
    input  logic            reti,
    output lvl_t            cur_lvl
);
    logic [NLVL-1:0] isv, popped, nxt;
    lvl_t            ack_lvl;

    assign ack_lvl = vec_level(ack_vec, vec_hi);

    always_comb begin
        logic found;
        found  = 1'b0;
        popped = isv;
        if (reti) begin
            for (int k = NLVL - 1; k >= 0; k--) begin
                if (!found && popped[k]) begin
                    popped[k] = 1'b0;
                    found     = 1'b1;
                end
            end
        end
        nxt = popped;
        if (ack) nxt[int'(ack_lvl) - 1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) isv <= '0;
        else     isv <= nxt;
    end

    always_comb begin
        cur_lvl = '0;
        for (int k = 0; k < NLVL; k++)
            if (isv[k]) cur_lvl = lvl_t'(k + 1);
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import ipc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        gl_en,
    input  logic [12:0] vec_en,
    input  logic [12:0] vec_hi,
    input  logic [1:0]  ext_n,
    input  logic [1:0]  ext_edge,
    input  logic        core_off,
    input  logic [1:0]  wake_ext,
    input  logic [1:0]  tmr_ovf,
    input  logic        temp_evt,
    input  logic        serp_evt,
    input  logic        uart_req,
    input  logic        tmr2_req,
    input  logic        uart2_req,
    input  logic        rtc_alarm,
    input  logic        rtc_tick,
    input  logic        wdt_req,
    input  logic        dsp_req,
    input  logic        psm_req,
    input  logic        ack,
    input  logic [3:0]  ack_vec,
    input  logic        reti,
    output logic        irq_req,
    output logic [3:0]  irq_vec,
    output logic [12:0] pend_o
);
    logic [NVEC-1:0] clr;
    lvl_t            cur_lvl;
    pick_t           pick;

    always_comb begin
        for (int v = 0; v < NVEC; v++)
            clr[v] = ack && (ack_vec == VW'(v));
    end

    ipc_sources u_src (
        .clk(clk), .rst(rst), .ext_n(ext_n), .ext_edge(ext_edge),
        .core_off(core_off), .wake_ext(wake_ext), .tmr_ovf(tmr_ovf),
        .temp_evt(temp_evt), .serp_evt(serp_evt), .uart_req(uart_req),
        .tmr2_req(tmr2_req), .uart2_req(uart2_req),
        .rtc_req(rtc_alarm | rtc_tick), .wdt_req(wdt_req),
        .dsp_req(dsp_req), .psm_req(psm_req), .clr(clr), .pend(pend_o)
    );

    ipc_service u_svc (
        .clk(clk), .rst(rst), .ack(ack), .ack_vec(ack_vec),
        .vec_hi(vec_hi), .reti(reti), .cur_lvl(cur_lvl)
    );

    ipc_arbiter u_arb (
        .gl_en(gl_en), .vec_en(vec_en), .vec_hi(vec_hi),
        .pend(pend_o), .cur_lvl(cur_lvl), .pick(pick)
    );

    assign irq_req = pick.req;
    assign irq_vec = pick.vec;
endmodule

// File: rtl/ipc_checks.sv
module ipc_checks (
    input logic        clk,
    input logic        rst,
    input logic        gl_en,
    input logic [12:0] vec_en,
    input logic [1:0]  ext_n,
    input logic        core_off,
    input logic [1:0]  wake_ext,
    input logic        temp_evt,
    input logic        rtc_alarm,
    input logic        rtc_tick,
    input logic        ack,
    input logic [3:0]  ack_vec,
    input logic        reti,
    input logic        irq_req,
    input logic [3:0]  irq_vec,
    input logic [12:0] pend_o
);
    logic top_busy;
    always_ff @(posedge clk) begin
        if (rst)                          top_busy <= 1'b0;
        else if (ack && ack_vec == 4'd12) top_busy <= 1'b1;
        else if (reti)                    top_busy <= 1'b0;
    end

    assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (gl_en && vec_en[irq_vec] && pend_o[irq_vec]));

    assert_range_R4: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec < 4'd13));

    assert_top_R3: assert property (@(posedge clk) disable iff (rst)
        (gl_en && vec_en[12] && pend_o[12] && !top_busy) |-> (irq_req && irq_vec == 4'd12));

    assert_latch_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_vec == 4'd7 && !temp_evt) |=> !pend_o[7]);

    assert_keep_R10: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_vec == 4'd9 && (rtc_alarm || rtc_tick)) |=> pend_o[9]);

    assert_sleep_R12: assert property (@(posedge clk) disable iff (rst)
        (core_off && !wake_ext[0] && !pend_o[0]) |=> !pend_o[0]);
endmodule

bind irq_pend_ctrl ipc_checks u_chk (
    .clk(clk), .rst(rst), .gl_en(gl_en), .vec_en(vec_en), .ext_n(ext_n),
    .core_off(core_off), .wake_ext(wake_ext), .temp_evt(temp_evt),
    .rtc_alarm(rtc_alarm), .rtc_tick(rtc_tick), .ack(ack), .ack_vec(ack_vec),
    .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec), .pend_o(pend_o)
);

// File: tb/irq_pend_ctrl_test.sv
`timescale 1ns/1ps
module irq_pend_ctrl_test;
    logic        clk = 0, rst = 1;
    logic        gl_en = 0;
    logic [12:0] vec_en = '1, vec_hi = '0;
    logic [1:0]  ext_n = 2'b11, ext_edge = 2'b11, wake_ext = 0, tmr_ovf = 0;
    logic        core_off = 0, temp_evt = 0, serp_evt = 0;
    logic        uart_req = 0, tmr2_req = 0, uart2_req = 0, rtc_alarm = 0, rtc_tick = 0;
    logic        wdt_req = 0, dsp_req = 0, psm_req = 0, ack = 0, reti = 0;
    logic [3:0]  ack_vec = 0;
    logic        irq_req;
    logic [3:0]  irq_vec;
    logic [12:0] pend_o;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_pend_ctrl uut (.*);

    // ---------------- reference model ----------------
    bit m_pinq[2], m_ef[2], m_wk[2], m_tf[2], m_temp, m_serp;
    bit m_src[13];
    bit m_isv[3];

    function automatic int lev(int v);
        if (v == 12) return 3;
        return vec_hi[v] ? 2 : 1;
    endfunction

    function automatic bit [12:0] m_pend();
        bit [12:0] p = '0;
        for (int e = 0; e < 2; e++) begin
            p[2*e]   = m_ef[e] || m_wk[e];
            p[2*e+1] = m_tf[e];
        end
        p[7] = m_temp;
        p[8] = m_serp;
        foreach (m_src[i]) if (m_src[i]) p[i] = 1'b1;
        return p;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < 2; e++) begin
                m_pinq[e] = 1; m_ef[e] = 0; m_wk[e] = 0; m_tf[e] = 0;
            end
            m_temp = 0; m_serp = 0;
            foreach (m_src[i]) m_src[i] = 0;
            foreach (m_isv[i]) m_isv[i] = 0;
        end else begin
            for (int e = 0; e < 2; e++) begin
                bit c;
                c = ack && ack_vec == 4'(2*e);
                if (!core_off) begin
                    if (ext_edge[e]) m_ef[e] = (m_pinq[e] && !ext_n[e]) || (m_ef[e] && !c);
                    else             m_ef[e] = !ext_n[e];
                end else if (ext_edge[e]) m_ef[e] = m_ef[e] && !c;
                m_pinq[e] = ext_n[e];
                m_wk[e] = wake_ext[e] || (m_wk[e] && !c);
                m_tf[e] = tmr_ovf[e] || (m_tf[e] && !(ack && ack_vec == 4'(2*e+1)));
            end
            m_temp = temp_evt || (m_temp && !(ack && ack_vec == 7));
            m_serp = serp_evt || (m_serp && !(ack && ack_vec == 8));
            m_src[4] = uart_req;  m_src[5] = tmr2_req; m_src[6] = uart2_req;
            m_src[9] = rtc_alarm || rtc_tick; m_src[10] = wdt_req;
            m_src[11] = dsp_req;  m_src[12] = psm_req;
            if (reti) begin
                if (m_isv[2]) m_isv[2] = 0;
                else if (m_isv[1]) m_isv[1] = 0;
                else m_isv[0] = 0;
            end
            if (ack) m_isv[lev(int'(ack_vec)) - 1] = 1;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison, away from the clock edge
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            int cur, best, bl;
            bit [12:0] p;
            p = m_pend();
            cur = m_isv[2] ? 3 : m_isv[1] ? 2 : m_isv[0] ? 1 : 0;
            best = -1; bl = 0;
            for (int v = 0; v < 13; v++)
                if (gl_en && vec_en[v] && p[v] && lev(v) > cur && lev(v) > bl) begin
                    best = v; bl = lev(v);
                end
            check(pend_o == p, "R11 model pend_o", pend_o, p);
            check(irq_req == (best >= 0), "R4 model irq_req", irq_req, best >= 0);
            if (best >= 0) check(irq_vec == 4'(best), "R4 model irq_vec", irq_vec, best);
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic step(); @(negedge clk); endtask
    task automatic enter(int v); ack = 1; ack_vec = 4'(v); step(); ack = 0; endtask
    task automatic leave(); reti = 1; step(); reti = 0; endtask

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        check(pend_o == 0, "R1 pend after reset", pend_o, 0);
        check(irq_req == 0, "R1 no request after reset", irq_req, 0);

        tmr_ovf = 2'b01; step(); tmr_ovf = 0;
        check(pend_o[1] == 1, "R8 timer0 pending", pend_o[1], 1);
        check(irq_req == 0, "R2 global enable off", irq_req, 0);
        gl_en = 1; #1;
        check(irq_req == 1 && irq_vec == 1, "R2 presented when enabled", irq_vec, 1);
        vec_en[1] = 0; #1;
        check(irq_req == 0, "R2 vector mask", irq_req, 0);
        check(pend_o[1] == 1, "R2 pending kept while masked", pend_o[1], 1);
        vec_en[1] = 1;
        enter(1);
        check(pend_o[1] == 0, "R8 entry clears timer", pend_o[1], 0);
        leave();

        ext_n = 2'b10; step(); ext_n = 2'b11;
        check(pend_o[0] == 1, "R6 falling edge sets", pend_o[0], 1);
        temp_evt = 1; step(); temp_evt = 0;
        uart_req = 1; step();
        check(irq_vec == 0, "R4 polling order", irq_vec, 0);
        vec_hi[7] = 1; #1;
        check(irq_vec == 7, "R4 high level wins", irq_vec, 7);
        psm_req = 1; step();
        check(irq_vec == 12, "R3 top level", irq_vec, 12);

        enter(12);
        check(pend_o[12] == 1, "R11 psm not cleared by entry", pend_o[12], 1);
        check(irq_req == 0, "R5 nothing preempts top", irq_req, 0);
        leave();
        check(irq_req == 1 && irq_vec == 12, "R5 reti pops level", irq_vec, 12);
        psm_req = 0; step();
        check(irq_vec == 7, "R11 psm drops with flags", irq_vec, 7);

        enter(7);
        check(pend_o[7] == 0, "R9 temp cleared on entry", pend_o[7], 0);
        check(irq_req == 0, "R5 low blocked by high", irq_req, 0);
        leave();
        check(irq_vec == 0, "R5 low served after reti", irq_vec, 0);
        enter(0);
        check(pend_o[0] == 0, "R6 entry clears edge flag", pend_o[0], 0);
        leave();
        check(irq_vec == 4, "R4 uart next", irq_vec, 4);
        enter(4);
        check(pend_o[4] == 1, "R11 uart kept after entry", pend_o[4], 1);
        leave();
        uart_req = 0; step();
        check(pend_o[4] == 0, "R11 uart cleared by software", pend_o[4], 0);

        rtc_alarm = 1; step();
        check(pend_o[9] == 1 && irq_vec == 9, "R10 rtc pending", irq_vec, 9);
        enter(9);
        check(pend_o[9] == 1, "R10 entry keeps rtc", pend_o[9], 1);
        leave();
        rtc_alarm = 0; step();
        check(pend_o[9] == 0, "R10 flag clear removes", pend_o[9], 0);

        ext_edge[1] = 0; ext_n[1] = 0; step();
        check(pend_o[2] == 1 && irq_vec == 2, "R7 level pending", irq_vec, 2);
        enter(2);
        check(pend_o[2] == 1, "R7 entry keeps level", pend_o[2], 1);
        leave();
        check(irq_req == 1 && irq_vec == 2, "R7 re-presented", irq_vec, 2);
        ext_n[1] = 1; step();
        check(pend_o[2] == 0, "R7 pin high removes", pend_o[2], 0);

        core_off = 1; ext_n[0] = 0; step(); step();
        check(pend_o[0] == 0, "R12 pin ignored in sleep", pend_o[0], 0);
        ext_n[0] = 1; step();
        wake_ext = 2'b01; step(); wake_ext = 0; step();
        check(pend_o[0] == 1, "R12 wake raises ext0", pend_o[0], 1);
        core_off = 0; step();
        enter(0);
        check(pend_o[0] == 0, "R12 wake cleared on entry", pend_o[0], 0);
        leave();

        vec_en[8] = 0; serp_evt = 1; step(); serp_evt = 0; step(); step();
        check(pend_o[8] == 1 && irq_req == 0, "R9 serial latch held while disabled", pend_o[8], 1);
        vec_en[8] = 1; #1;
        check(irq_vec == 8, "R9 served once enabled", irq_vec, 8);
        enter(8);
        check(pend_o[8] == 0, "R9 serial cleared on entry", pend_o[8], 0);
        leave();
        step();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule